// File: doc/BRIEF.md
# Dual-Port Word Memory with Byte-Lane Selects

This block is a shared memory with two independent ports, called left and right, that sit on a common clock. Each port has an active-low chip enable, a read/write line (low means write), an active-low output enable, two active-low lane selects and an active-low semaphore select, plus an address, write data and read data. Each word is split into two lanes that can be written or read on their own. An access only reaches the array when the semaphore select is inactive (high).

Reads are registered. The read data and a two-bit per-lane valid flag appear one clock after the request. The valid flag replaces the tri-state enable of a bidirectional bus. A lane that is not driven returns zero. Both ports can reach every word. When both ports write the same word in the same cycle, the left port wins on each lane that both ports enable. A read that meets a write from the other port to the same word in the same cycle returns the contents from before that write.

Top module: `dp_lane_ram`

## Requirements
- R1: Bits [2*LANE_W-1:LANE_W] form the upper lane, governed by the upper select `*_up_n`. Bits [LANE_W-1:0] form the lower lane, governed by `*_lo_n`. In `*_rvalid`, bit 1 flags the upper lane and bit 0 the lower lane.
- R2: When a port's chip enable is high, that port neither writes the array nor returns data, and its `*_rvalid` is 00 on the next cycle.
- R3: When chip enable is low but both lane selects are high, no lane is written and `*_rvalid` is 00 on the next cycle.
- R4: A write happens when chip enable is low, read/write is low and the semaphore select is high, whatever the output enable is. Only the lanes whose select is low change. The other lanes keep their contents.
- R5: A read needs chip enable low, read/write high, output enable low and semaphore select high. One cycle later, `*_rvalid` equals the inverted lane selects and the selected lanes carry the stored data. A lane that is not valid reads as zero.
- R6: With output enable high, a read request returns `*_rvalid` = 00 and zero data, whatever the lane selects are.
- R7: With the semaphore select low, a port neither writes nor reads the array, and `*_rvalid` is 00 on the next cycle.
- R8: Both ports reach every address from 0 to 2^ADDR_W-1. A word written by one port is read back by the other.
- R9: Both ports may read the same word in the same cycle, and both get its data.
- R10: When both ports write the same word in the same cycle, each lane that both enable takes the left data. A lane that only one port enables takes that port's data.
- R11: A read of a word that the other port writes in the same cycle returns the data from before the write. A later read returns the new data.
- R12: After reset, both `*_rvalid` outputs and both `*_rdata` outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left read/write, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_up_n | input | 1 | Left upper-lane select, active low |
| l_lo_n | input | 1 | Left lower-lane select, active low |
| l_sem_n | input | 1 | Left semaphore select; array access only when high |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data, one cycle after request |
| l_rvalid | output | 2 | Left per-lane data valid |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right read/write, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_up_n | input | 1 | Right upper-lane select, active low |
| r_lo_n | input | 1 | Right lower-lane select, active low |
| r_sem_n | input | 1 | Right semaphore select; array access only when high |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data, one cycle after request |
| r_rvalid | output | 2 | Right per-lane data valid |

## Verification
The bench builds the block with ADDR_W = 13 and LANE_W = 9, which gives the full 8K-word, 18-bit configuration. With these values the top word 8191 and word 0 can be written from one port and read from the other. Nine-bit lanes let the lane patterns set the ninth bit, so a lane swap or a truncated slice changes the value read back. Collision cases mix lanes enabled by both ports with lanes enabled by only one.

// File: rtl/dp_lane_ram.sv
module dp_lane_ram #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  l_ce_n,
  input  logic                  l_we_n,
  input  logic                  l_oe_n,
  input  logic                  l_up_n,
  input  logic                  l_lo_n,
  input  logic                  l_sem_n,
  input  logic [ADDR_W-1:0]     l_addr,
  input  logic [2*LANE_W-1:0]   l_wdata,
  output logic [2*LANE_W-1:0]   l_rdata,
  output logic [1:0]            l_rvalid,
  input  logic                  r_ce_n,
  input  logic                  r_we_n,
  input  logic                  r_oe_n,
  input  logic                  r_up_n,
  input  logic                  r_lo_n,
  input  logic                  r_sem_n,
  input  logic [ADDR_W-1:0]     r_addr,
  input  logic [2*LANE_W-1:0]   r_wdata,
  output logic [2*LANE_W-1:0]   r_rdata,
  output logic [1:0]            r_rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0][LANE_W-1:0] mem [DEPTH];

  wire       l_acc  = !l_ce_n && l_sem_n;
  wire       r_acc  = !r_ce_n && r_sem_n;
  wire [1:0] l_lane = {~l_up_n, ~l_lo_n};
  wire [1:0] r_lane = {~r_up_n, ~r_lo_n};
  wire [1:0] l_wen  = (l_acc && !l_we_n) ? l_lane : 2'b00;
  wire [1:0] r_wen  = (r_acc && !r_we_n) ? r_lane : 2'b00;
  wire [1:0] l_ren  = (l_acc && l_we_n && !l_oe_n) ? l_lane : 2'b00;
  wire [1:0] r_ren  = (r_acc && r_we_n && !r_oe_n) ? r_lane : 2'b00;

  // right first, left last: left data wins a shared lane
  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (r_wen[k]) mem[r_addr][k] <= r_wdata[k*LANE_W +: LANE_W];
      if (l_wen[k]) mem[l_addr][k] <= l_wdata[k*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rvalid <= 2'b00;
      r_rvalid <= 2'b00;
      l_rdata  <= '0;
      r_rdata  <= '0;
    end else begin
      l_rvalid <= l_ren;
      r_rvalid <= r_ren;
      for (int k = 0; k < 2; k++) begin
        l_rdata[k*LANE_W +: LANE_W] <= l_ren[k] ? mem[l_addr][k] : '0;
        r_rdata[k*LANE_W +: LANE_W] <= r_ren[k] ? mem[r_addr][k] : '0;
      end
    end
  end

  AST_L_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    l_ce_n |=> l_rvalid == 2'b00);  // R2
  AST_R_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    r_ce_n |=> r_rvalid == 2'b00);  // R2
  AST_L_NO_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (l_up_n && l_lo_n) |=> l_rvalid == 2'b00);  // R3
  AST_L_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !l_we_n |=> l_rvalid == 2'b00);  // R4
  AST_L_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && l_we_n && !l_oe_n && l_sem_n) |=> l_rvalid == ~$past({l_up_n, l_lo_n}));  // R5
  AST_R_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && r_we_n && !r_oe_n && r_sem_n) |=> r_rvalid == ~$past({r_up_n, r_lo_n}));  // R5
  AST_L_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rvalid[1] |-> l_rdata[2*LANE_W-1:LANE_W] == '0);  // R5
  AST_R_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rvalid[0] |-> r_rdata[LANE_W-1:0] == '0);  // R5
  AST_L_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    l_oe_n |=> l_rvalid == 2'b00);  // R6
  AST_R_SEM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !r_sem_n |=> r_rvalid == 2'b00);  // R7
endmodule

// File: tb/test_dp_lane_ram.sv
module test_dp_lane_ram;
  localparam int AW = 13;
  localparam int LW = 9;
  localparam int DW = 2 * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n, l_we_n, l_oe_n, l_up_n, l_lo_n, l_sem_n;
  logic r_ce_n, r_we_n, r_oe_n, r_up_n, r_lo_n, r_sem_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic [1:0] l_rvalid, r_rvalid;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dp_lane_ram #(.ADDR_W(AW), .LANE_W(LW)) i_dp_lane_ram (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_up_n(l_up_n),
    .l_lo_n(l_lo_n), .l_sem_n(l_sem_n), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_up_n(r_up_n),
    .r_lo_n(r_lo_n), .r_sem_n(r_sem_n), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_l(input logic ce, we, oe, up, lo, sem, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce_n = ce; l_we_n = we; l_oe_n = oe; l_up_n = up; l_lo_n = lo; l_sem_n = sem;
    l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic ce, we, oe, up, lo, sem, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce_n = ce; r_we_n = we; r_oe_n = oe; r_up_n = up; r_lo_n = lo; r_sem_n = sem;
    r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(1, 1, 1, 1, 1, 1, '0, '0);
    set_r(1, 1, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic up, lo);
    idle(); set_l(0, 0, 1, up, lo, 1, a, d); cyc(); idle();
  endtask

  task automatic wr_r(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic up, lo);
    idle(); set_r(0, 0, 1, up, lo, 1, a, d); cyc(); idle();
  endtask

  task automatic rd_l(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic [1:0] v);
    idle(); set_l(0, 1, 0, 0, 0, 1, a, '0); cyc(); d = l_rdata; v = l_rvalid; idle();
  endtask

  task automatic rd_r(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic [1:0] v);
    idle(); set_r(0, 1, 0, 0, 0, 1, a, '0); cyc(); d = r_rdata; v = r_rvalid; idle();
  endtask

  task automatic t_reset();
    chk("R12 l_rvalid", DW'(l_rvalid), '0);
    chk("R12 r_rvalid", DW'(r_rvalid), '0);
    chk("R12 l_rdata", l_rdata, '0);
    chk("R12 r_rdata", r_rdata, '0);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] d; logic [1:0] v;
    wr_l(10, {9'h1A5, 9'h05A}, 0, 0);
    rd_r(10, d, v);
    chk("R4 full write", d, {9'h1A5, 9'h05A});
    chk("R5 valid both", DW'(v), DW'(2'b11));
    wr_l(10, {9'h0F0, 9'h111}, 0, 1);
    rd_r(10, d, v);
    chk("R1 upper-only write", d, {9'h0F0, 9'h05A});
    wr_r(10, {9'h1FF, 9'h033}, 1, 0);
    rd_l(10, d, v);
    chk("R1 lower-only write", d, {9'h0F0, 9'h033});
  endtask

  task automatic t_read_lane();
    idle(); set_l(0, 1, 0, 0, 1, 1, 10, '0); cyc();
    chk("R5 upper read valid", DW'(l_rvalid), DW'(2'b10));
    chk("R5 upper read data", l_rdata, {9'h0F0, 9'h000});
    idle(); set_r(0, 1, 0, 1, 0, 1, 10, '0); cyc();
    chk("R1 lower read valid", DW'(r_rvalid), DW'(2'b01));
    chk("R1 lower read data", r_rdata, {9'h000, 9'h033});
    idle();
  endtask

  task automatic t_oe();
    logic [DW-1:0] d; logic [1:0] v;
    idle(); set_l(0, 1, 1, 0, 0, 1, 10, '0); cyc();
    chk("R6 oe high valid", DW'(l_rvalid), '0);
    chk("R6 oe high data", l_rdata, '0);
    idle(); set_l(0, 0, 0, 0, 0, 1, 20, {9'h055, 9'h0AA}); cyc(); idle();
    rd_r(20, d, v);
    chk("R4 write with oe low", d, {9'h055, 9'h0AA});
  endtask

  task automatic t_ce();
    logic [DW-1:0] d; logic [1:0] v;
    idle(); set_l(1, 0, 1, 0, 0, 1, 20, {9'h1C3, 9'h13C}); cyc();
    chk("R2 deselected valid", DW'(l_rvalid), '0);
    idle(); set_r(1, 1, 0, 0, 0, 1, 20, '0); cyc();
    chk("R2 deselected read", DW'(r_rvalid), '0);
    rd_l(20, d, v);
    chk("R2 no write when deselected", d, {9'h055, 9'h0AA});
  endtask

  task automatic t_nobytes();
    logic [DW-1:0] d; logic [1:0] v;
    wr_r(20, {9'h1C3, 9'h13C}, 1, 1);
    idle(); set_l(0, 1, 0, 1, 1, 1, 20, '0); cyc();
    chk("R3 no-lane read valid", DW'(l_rvalid), '0);
    rd_l(20, d, v);
    chk("R3 no-lane write ignored", d, {9'h055, 9'h0AA});
  endtask

  task automatic t_sem();
    logic [DW-1:0] d; logic [1:0] v;
    idle(); set_l(0, 0, 1, 0, 0, 0, 20, {9'h1C3, 9'h13C}); cyc();
    idle(); set_r(0, 1, 0, 0, 0, 0, 20, '0); cyc();
    chk("R7 sem read valid", DW'(r_rvalid), '0);
    rd_r(20, d, v);
    chk("R7 sem write ignored", d, {9'h055, 9'h0AA});
  endtask

  task automatic t_range();
    logic [DW-1:0] d; logic [1:0] v;
    wr_r(AW'((1 << AW) - 1), {9'h1E1, 9'h11E}, 0, 0);
    wr_l(0, {9'h100, 9'h001}, 0, 0);
    rd_l(AW'((1 << AW) - 1), d, v);
    chk("R8 top address", d, {9'h1E1, 9'h11E});
    rd_r(0, d, v);
    chk("R8 address zero", d, {9'h100, 9'h001});
  endtask

  task automatic t_dualread();
    idle();
    set_l(0, 1, 0, 0, 0, 1, 10, '0);
    set_r(0, 1, 0, 0, 0, 1, 10, '0);
    cyc();
    chk("R9 left same-word read", l_rdata, {9'h0F0, 9'h033});
    chk("R9 right same-word read", r_rdata, {9'h0F0, 9'h033});
    idle();
  endtask

  task automatic t_collide();
    logic [DW-1:0] d; logic [1:0] v;
    idle();
    set_l(0, 0, 1, 0, 0, 1, 30, {9'h101, 9'h102});
    set_r(0, 0, 1, 0, 0, 1, 30, {9'h1EE, 9'h1DD});
    cyc(); idle();
    rd_l(30, d, v);
    chk("R10 left wins both lanes", d, {9'h101, 9'h102});
    set_l(0, 0, 1, 0, 1, 1, 30, {9'h011, 9'h0BB});
    set_r(0, 0, 1, 0, 0, 1, 30, {9'h022, 9'h044});
    cyc(); idle();
    rd_r(30, d, v);
    chk("R10 mixed lanes", d, {9'h011, 9'h044});
  endtask

  task automatic t_rw();
    logic [DW-1:0] d; logic [1:0] v;
    idle();
    set_l(0, 0, 1, 0, 0, 1, 30, {9'h123, 9'h145});
    set_r(0, 1, 0, 0, 0, 1, 30, '0);
    cyc();
    chk("R11 read sees old data", r_rdata, {9'h011, 9'h044});
    idle();
    rd_r(30, d, v);
    chk("R11 later read sees new data", d, {9'h123, 9'h145});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lanes();
    t_read_lane();
    t_oe();
    t_ce();
    t_nobytes();
    t_sem();
    t_range();
    t_dualread();
    t_collide();
    t_rw();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule